// File: doc/BRIEF.md
# ISA Card-Select and Zero-Wait-State Line Driver

This block lives on an 8-bit ISA expansion card and controls the shared B8 backplane line, which is active low. It compares the card's I/O window against the upper address bits with AEN low. When the card is the target of the current strobe, it pulls B8 low. The line is wired-OR with other drivers on the system board, such as the ROM decoder. The block therefore never drives it high. When idle, it releases the line to high impedance and an external pull-up holds it high.

A mode pin selects one of two meanings for the line. In XT mode the line is a card-selected indication and is pulled low only on reads from the card. The system board then turns its data buffer toward the card. In AT mode the line is a zero-wait-state request and qualifies on both reads and writes. Without this request the host stretches every 8-bit cycle to about 750 ns. The decode and the pull-down are purely combinational, so the line releases in the same instant the strobe rises. An activity LED output follows any read or write that selects the card, in either mode.

Each strobe pair is sorted into one of four cycle kinds: IDLE (neither strobe low), READ (only IOR low), WRITE (only IOW low) and CLASH (both low). The qualifier maps each kind to a pull decision for the current mode. IDLE never pulls. READ pulls in both modes. WRITE pulls in AT mode only. CLASH pulls in both modes, because its read part is always enough. There are no transitions between kinds. The kind is recomputed from the strobes at every instant.

Top module: `isa_b8_select`

## Requirements
- R1: The card is hit when the address bits 9..3 on `sa_hi` equal the parameter `WIN_BASE` (default 7'h64, I/O 0x320 to 0x327) and `aen` is 0.
- R2: With `mode_at` = 0 (XT), `b8_oe` is 1 exactly when the card is hit and `ior_n` is 0. A write strobe alone never enables it.
- R3: With `mode_at` = 1 (AT), `b8_oe` is 1 exactly when the card is hit and either `ior_n` or `iow_n` is 0.
- R4: `b8_out` is 0 whenever `b8_oe` is 1, so the block never drives the line high. The bench also checks this on a wired line shared with a foreign pull-down.
- R5: With `aen` = 1 (DMA cycle), `b8_oe` and `led` stay 0 for any address and strobe.
- R6: An address outside the window never enables `b8_oe` or `led`.
- R7: `b8_oe` follows its inputs combinationally. It releases in the same clock period in which the qualifying strobe rises, with no register delay.
- R8: `led` (active high by default) is 1 exactly when the card is hit and either strobe is 0, regardless of `mode_at`.
- R9: While `rst_n` is 0, `b8_oe` and `led` are 0.
- R10: When both strobes are 0 at once (CLASH), the line is pulled in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock for the guard properties |
| rst_n | input | 1 | Active-low reset; forces the line released |
| mode_at | input | 1 | 0 = XT card-selected use, 1 = AT zero-wait use |
| sa_hi | input | 7 | ISA address bits 9..3 |
| aen | input | 1 | DMA address enable, high during DMA |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| b8_out | output | 1 | Value presented to the B8 pad, always 0 |
| b8_oe | output | 1 | Pad enable; 1 pulls B8 low, 0 releases it |
| led | output | 1 | Card activity indication |

## Verification
Two things can fall in the same cycle on the shared line: this card pulls B8 low while a foreign driver, standing in for the ROM decoder, also pulls it low. The bench models the wired line with a pull-up and raises the foreign pull-down at random during reads and writes to the window. It then checks that the resolved line is low and that this block never presents a high value while enabled. The bench also drives reads and writes to the same cycle, with both strobes low, under each mode setting. It judges the pull decision and the LED against separately computed expectations.

// File: rtl/isa_b8_pkg.sv
package isa_b8_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2,
        CYC_CLASH = 2'd3
    } cyc_kind_t;

    typedef enum logic {
        MODE_XT = 1'b0,
        MODE_AT = 1'b1
    } line_mode_t;

endpackage

// File: rtl/isa_win_decode.sv
module isa_win_decode #(
    parameter int ADDR_W  = 10,
    parameter int DEC_LSB = 3,
    localparam int CMP_W  = ADDR_W - DEC_LSB,
    parameter logic [CMP_W-1:0] WIN_BASE = 7'h64
) (
    input  logic [CMP_W-1:0] sa_hi,
    input  logic             aen,
    output logic             hit
);

    logic addr_eq;

    always_comb begin
        addr_eq = (sa_hi == WIN_BASE);
        hit     = addr_eq && !aen;
    end

    // R5: a DMA cycle never reports a hit
    always_comb begin
        if (aen) begin
            a_r5_aen_no_hit: assert (!hit);
        end
    end

endmodule

// File: rtl/isa_strobe_qual.sv
module isa_strobe_qual
    import isa_b8_pkg::*;
(
    input  logic ior_n,
    input  logic iow_n,
    input  logic mode_at,
    output cyc_kind_t kind,
    output logic pull,
    output logic active
);

    line_mode_t mode;

    always_comb begin
        mode = line_mode_t'(mode_at);
        unique case ({ior_n, iow_n})
            2'b11:   kind = CYC_IDLE;
            2'b01:   kind = CYC_READ;
            2'b10:   kind = CYC_WRITE;
            default: kind = CYC_CLASH;
        endcase
    end

    always_comb begin
        pull   = 1'b0;
        active = 1'b0;
        unique case (kind)
            CYC_IDLE: begin
                pull   = 1'b0;
                active = 1'b0;
            end
            CYC_READ: begin
                pull   = 1'b1;
                active = 1'b1;
            end
            CYC_WRITE: begin
                pull   = (mode == MODE_AT);
                active = 1'b1;
            end
            CYC_CLASH: begin
                pull   = 1'b1;
                active = 1'b1;
            end
            default: begin
                pull   = 1'b0;
                active = 1'b0;
            end
        endcase
    end

    // R2: a lone write in XT mode never qualifies
    always_comb begin
        if (!mode_at && ior_n) begin
            a_r2_xt_write_blocked: assert (!pull);
        end
    end

endmodule

// File: rtl/isa_od_driver.sv
module isa_od_driver #(
    parameter bit LED_ACT_LOW = 1'b0
) (
    input  logic rst_n,
    input  logic sel_pull,
    input  logic sel_active,
    output logic pad_out,
    output logic pad_oe,
    output logic led
);

    logic led_on;

    always_comb begin
        pad_out = 1'b0;
        pad_oe  = rst_n && sel_pull;
        led_on  = rst_n && sel_active;
    end

    generate
        if (LED_ACT_LOW) begin : g_led_low
            assign led = !led_on;
        end else begin : g_led_high
            assign led = led_on;
        end
    endgenerate

    // R4: the pad value is low whenever the enable is on
    always_comb begin
        if (pad_oe) begin
            a_r4_no_high_drive: assert (pad_out == 1'b0);
        end
    end

endmodule

// File: rtl/isa_b8_select.sv
module isa_b8_select
    import isa_b8_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DEC_LSB = 3,
    localparam int CMP_W  = ADDR_W - DEC_LSB,
    parameter logic [CMP_W-1:0] WIN_BASE = 7'h64,
    parameter bit LED_ACT_LOW = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_at,
    input  logic [CMP_W-1:0] sa_hi,
    input  logic             aen,
    input  logic             ior_n,
    input  logic             iow_n,
    output logic             b8_out,
    output logic             b8_oe,
    output logic             led
);

    logic      hit;
    cyc_kind_t kind;
    logic      strobe_pull;
    logic      strobe_active;
    logic      sel_pull;
    logic      sel_active;

    isa_win_decode #(
        .ADDR_W  (ADDR_W),
        .DEC_LSB (DEC_LSB),
        .WIN_BASE(WIN_BASE)
    ) u_dec (
        .sa_hi(sa_hi),
        .aen  (aen),
        .hit  (hit)
    );

    isa_strobe_qual u_qual (
        .ior_n  (ior_n),
        .iow_n  (iow_n),
        .mode_at(mode_at),
        .kind   (kind),
        .pull   (strobe_pull),
        .active (strobe_active)
    );

    always_comb begin
        sel_pull   = hit && strobe_pull;
        sel_active = hit && strobe_active;
    end

    isa_od_driver #(
        .LED_ACT_LOW(LED_ACT_LOW)
    ) u_drv (
        .rst_n     (rst_n),
        .sel_pull  (sel_pull),
        .sel_active(sel_active),
        .pad_out   (b8_out),
        .pad_oe    (b8_oe),
        .led       (led)
    );

    // R4: enabled pad never carries a high value
    a_r4_oe_low_value: assert property (@(posedge clk) disable iff (!rst_n)
        b8_oe |-> !b8_out);

    // R5: DMA cycles never pull the line
    a_r5_dma_release: assert property (@(posedge clk) disable iff (!rst_n)
        aen |-> !b8_oe);

    // R6: out-of-window addresses never pull the line
    a_r6_outside_release: assert property (@(posedge clk) disable iff (!rst_n)
        (sa_hi != WIN_BASE) |-> !b8_oe);

    // R3: AT mode pulls on a write to the window
    a_r3_at_write_pull: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_at && !aen && (sa_hi == WIN_BASE) && !iow_n) |-> b8_oe);

    // R10: clash of both strobes pulls in either mode
    a_r10_clash_pull: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_CLASH && hit) |-> b8_oe);

    // R9: reset releases the line
    always_comb begin
        if (!rst_n) begin
            a_r9_reset_release: assert (!b8_oe);
        end
    end

endmodule

// File: tb/isa_b8_select_tb.sv
module isa_b8_select_tb_top;

    localparam logic [6:0] BASE = 7'h64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_at = 1'b0;
    logic [6:0] sa_hi = 7'h00;
    logic       aen = 1'b1;
    logic       ior_n = 1'b1;
    logic       iow_n = 1'b1;
    logic       foreign_low = 1'b0;
    logic       b8_out;
    logic       b8_oe;
    logic       led;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    isa_b8_select #(.WIN_BASE(BASE)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_at(mode_at),
        .sa_hi  (sa_hi),
        .aen    (aen),
        .ior_n  (ior_n),
        .iow_n  (iow_n),
        .b8_out (b8_out),
        .b8_oe  (b8_oe),
        .led    (led)
    );

    function automatic bit exp_hit(logic [6:0] a, logic e);
        return (a == BASE) && !e;
    endfunction

    function automatic bit exp_oe(bit r, bit m, logic [6:0] a, logic e, logic rd_n, logic wr_n);
        return r && exp_hit(a, e) && (!rd_n || (m && !wr_n));
    endfunction

    function automatic bit exp_led(bit r, logic [6:0] a, logic e, logic rd_n, logic wr_n);
        return r && exp_hit(a, e) && (!rd_n || !wr_n);
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (mode=%b a=%h aen=%b ior_n=%b iow_n=%b)",
                     req, act, exp, mode_at, sa_hi, aen, ior_n, iow_n);
        end
    endtask

    task automatic check_all(string req);
        logic line;
        check({req, " oe"}, b8_oe, exp_oe(rst_n, mode_at, sa_hi, aen, ior_n, iow_n));
        check({req, " led"}, led, exp_led(rst_n, sa_hi, aen, ior_n, iow_n));
        if (b8_oe) check("R4 pad value", b8_out, 1'b0);
        line = (b8_oe && !b8_out) ? 1'b0 : (foreign_low ? 1'b0 : 1'b1);
        if (b8_oe || foreign_low) check("R4 wired line low", line, 1'b0);
    endtask

    task automatic apply(bit m, logic [6:0] a, logic e, logic rd_n, logic wr_n, string req);
        @(negedge clk);
        mode_at = m; sa_hi = a; aen = e; ior_n = rd_n; iow_n = wr_n;
        #1;
        check_all(req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h1bad5eed));
        // R9: reset holds the line released even for a qualifying read
        apply(1'b1, BASE, 1'b0, 1'b0, 1'b0, "R9 reset");
        check("R9 oe in reset", b8_oe, 1'b0);
        check("R9 led in reset", led, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(1'b0, BASE, 1'b0, 1'b1, 1'b1, "R1 idle");
        // R2: XT read pulls, write does not
        apply(1'b0, BASE, 1'b0, 1'b0, 1'b1, "R2 xt read");
        check("R2 xt read oe", b8_oe, 1'b1);
        apply(1'b0, BASE, 1'b0, 1'b1, 1'b0, "R2 xt write");
        check("R2 xt write oe", b8_oe, 1'b0);
        check("R8 xt write led", led, 1'b1);
        // R3: AT read and write both pull
        apply(1'b1, BASE, 1'b0, 1'b0, 1'b1, "R3 at read");
        apply(1'b1, BASE, 1'b0, 1'b1, 1'b0, "R3 at write");
        check("R3 at write oe", b8_oe, 1'b1);
        // R10: clash in both modes
        apply(1'b0, BASE, 1'b0, 1'b0, 1'b0, "R10 xt clash");
        check("R10 xt clash oe", b8_oe, 1'b1);
        apply(1'b1, BASE, 1'b0, 1'b0, 1'b0, "R10 at clash");
        check("R10 at clash oe", b8_oe, 1'b1);
        // R5: DMA blocks
        apply(1'b1, BASE, 1'b1, 1'b0, 1'b0, "R5 dma");
        check("R5 dma oe", b8_oe, 1'b0);
        check("R5 dma led", led, 1'b0);
        // R6: neighbours of the window
        apply(1'b1, BASE + 7'd1, 1'b0, 1'b0, 1'b1, "R6 above");
        apply(1'b1, BASE - 7'd1, 1'b0, 1'b1, 1'b0, "R6 below");
        check("R6 below led", led, 1'b0);
        // R7: release in the same period the strobe rises
        apply(1'b1, BASE, 1'b0, 1'b0, 1'b1, "R7 setup");
        @(posedge clk);
        #2;
        ior_n = 1'b1;
        #1;
        check("R7 release same cycle", b8_oe, 1'b0);
        check("R8 led release", led, 1'b0);
        // R4: foreign pull-down during own pull
        apply(1'b1, BASE, 1'b0, 1'b0, 1'b1, "R4 setup");
        foreign_low = 1'b1;
        #1;
        check_all("R4 shared");
        foreign_low = 1'b0;
        // random mix, address biased toward the window
        for (int i = 0; i < 3000; i++) begin
            logic [6:0] a;
            a = ($urandom_range(0, 2) != 0) ? BASE : 7'($urandom);
            foreign_low = 1'($urandom);
            apply(1'($urandom), a, ($urandom_range(0, 5) == 0),
                  1'($urandom), 1'($urandom), "R1 R2 R3 R8 random");
        end
        foreign_low = 1'b0;
        // R9: reset reasserted mid-read
        apply(1'b1, BASE, 1'b0, 1'b0, 1'b1, "R9 pre");
        rst_n = 1'b0;
        #1;
        check("R9 async release", b8_oe, 1'b0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule